// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This peripheral holds several independent down counters behind a small synchronous register bus. Each channel has a control word, an interval word and a read-only count word. A channel moves only on pulses of a shared `tick_en` input, further divided by a per-channel power-of-two prescaler. When a channel's count is zero, the next step raises the channel's pending flag. In periodic mode the channel then reloads from its interval. In one-shot mode it clears its own enable and stays at zero.

Two shared words hold the per-channel interrupt enables and the pending flags. Pending flags are cleared by writing ones to them. A single level interrupt line is high while any channel has both its pending flag and its enable set.

Stopping a channel is not immediate. After software clears the enable of a running channel, that channel still acts on a fixed number of further tick pulses before it freezes. Software that reprograms a channel therefore waits that long.

Top module: `mmio_dn_timer`

## Requirements
- R1: After reset, every readable word is zero, all channels are stopped and `irq` is low.
- R2: Word offsets are as follows. The interrupt-enable word is at 0x00, with bit n for channel n. The pending word is at 0x04. Channel n uses 0x10*n+0x10 for control, 0x10*n+0x14 for interval and 0x10*n+0x18 for count. The count word ignores writes. Any other offset reads as zero, and `bus_rdata` is zero unless a read is in progress.
- R3: The control fields are: bit 0 enable, bit 1 load request, bits 3:2 a stored source code, bits 6:4 the prescale code and bit 7 one-shot. The load request always reads back as 0. The source code is read back unchanged and has no other effect.
- R4: A control write with enable and load both set copies the interval into the count and restarts the prescaler. Enable without load resumes from the present count. In the cycle of a control write, that channel ignores `tick_en`.
- R5: A running channel steps once every 2^code `tick_en` pulses, where code is the prescale code. Without `tick_en` pulses its count does not change.
- R6: In periodic mode, a step taken at count zero sets the channel's pending flag and loads the interval. The period is therefore interval+1 steps.
- R7: In one-shot mode, a step taken at count zero sets the pending flag, clears the enable bit and stops the channel at zero.
- R8: After a control write clears the enable of a running channel, the channel processes exactly SYNC_TICKS further `tick_en` pulses. It then freezes.
- R9: Writing a 1 to a pending bit clears it. If the channel expires in the same cycle, the set wins. Pending bits stay set until they are cleared.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick pulse, one clock wide per tick |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational, valid during a read |
| irq | output | 1 | Level interrupt |

## Verification
The counters are first run with `tick_en` high on every cycle, which shows the basic step, expiry and reload timing. They are then run with a pseudo-random tick pattern, which separates steps that follow `tick_en` from steps that follow the clock, and which tests the prescale divide. Setting the interval to zero makes a channel expire on every tick, so a clear-on-write of its pending bit always lands on an expiry; this shows which of the two takes priority. A disable issued under a steady tick stream, followed by an idle stream, measures how far the channel coasts and confirms that it then stays frozen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PS_W  = 3;
    localparam int SRC_W = 2;

    typedef struct packed {
        logic             oneshot;
        logic [PS_W-1:0]  ps;
        logic [SRC_W-1:0] src;
        logic             en;
    } ctrl_t;

    function automatic logic [7:0] ctrl_pack(ctrl_t c);
        return {c.oneshot, c.ps, c.src, 1'b0, c.en};
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [7:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.src     = w[3:2];
        c.ps      = w[6:4];
        c.oneshot = w[7];
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [PS_W-1:0] ps,
    output logic            step
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } state_t;

    state_t           st_d, st_q;
    logic [DIV_W:0]   full;
    logic [DIV_W-1:0] limit;

    always_comb begin
        full  = (DIV_W+1)'(1) << ps;
        limit = DIV_W'(full - (DIV_W+1)'(1));
        step  = tick && (st_q.pre == limit);
        st_d  = st_q;
        if (clear) begin
            st_d.pre = '0;
        end else if (tick) begin
            st_d.pre = step ? '0 : st_q.pre + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic             ival_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [7:0]       ctrl_rd,
    output logic [CNT_W-1:0] ival,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire,
    output logic             oneshot,
    output logic             enabled
);
    localparam int DR_W = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] ival;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic [DR_W-1:0]  drain;
    } state_t;

    state_t st_d, st_q;
    ctrl_t  wr_ctrl;
    logic   gated_tick;
    logic   load;
    logic   step;

    tmr_prescaler #(.PS_W(PS_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(load),
        .tick (gated_tick),
        .ps   (st_q.ctrl.ps),
        .step (step)
    );

    always_comb begin
        st_d       = st_q;
        expire     = 1'b0;
        load       = 1'b0;
        wr_ctrl    = ctrl_unpack(wdata[7:0]);
        gated_tick = tick && st_q.run && !ctrl_we;

        if (ctrl_we) begin
            st_d.ctrl = wr_ctrl;
            if (wr_ctrl.en) begin
                st_d.run   = 1'b1;
                st_d.drain = '0;
                if (wdata[1]) begin
                    st_d.cnt = st_q.ival;
                    load     = 1'b1;
                end
            end else if (st_q.run && st_q.drain == '0) begin
                st_d.drain = DR_W'(SYNC_TICKS);
            end
        end else if (gated_tick) begin
            if (step) begin
                if (st_q.cnt == '0) begin
                    expire = 1'b1;
                    if (st_q.ctrl.oneshot) begin
                        st_d.ctrl.en = 1'b0;
                        st_d.run     = 1'b0;
                        st_d.drain   = '0;
                    end else begin
                        st_d.cnt = st_q.ival;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            if (st_q.drain != '0 && st_d.run) begin
                st_d.drain = st_q.drain - DR_W'(1);
                if (st_q.drain == DR_W'(1)) st_d.run = 1'b0;
            end
        end

        if (ival_we) st_d.ival = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rd = ctrl_pack(st_q.ctrl);
    assign ival    = st_q.ival;
    assign count   = st_q.cnt;
    assign running = st_q.run;
    assign oneshot = st_q.ctrl.oneshot;
    assign enabled = st_q.ctrl.en;

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we,
    input  logic              ist_we,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ien,
    output logic [NUM_CH-1:0] ist,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] ien;
        logic [NUM_CH-1:0] ist;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ien_we) st_d.ien = wdata;
        st_d.ist = (st_q.ist & ~(ist_we ? wdata : '0)) | expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien = st_q.ien;
    assign ist = st_q.ist;
    assign irq = |(st_q.ist & st_q.ien);

endmodule

// File: rtl/mmio_dn_timer.sv
module mmio_dn_timer #(
    parameter int NUM_CH     = 2,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ADDR_IEN = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_IST = ADDR_W'(4);

    function automatic logic [ADDR_W-1:0] ch_base(int i);
        return ADDR_W'(16 * (i + 1));
    endfunction

    logic                          bus_wr_cyc;
    logic                          bus_rd_cyc;
    logic [NUM_CH-1:0]             ctrl_we;
    logic [NUM_CH-1:0]             ival_we;
    logic [NUM_CH-1:0][7:0]        ch_ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_ival;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0]             ch_run;
    logic [NUM_CH-1:0]             ch_expire;
    logic [NUM_CH-1:0]             ch_oneshot;
    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0]             ien;
    logic [NUM_CH-1:0]             ist;
    logic                          ien_we;
    logic                          ist_we;

    assign bus_wr_cyc = bus_sel && bus_wr;
    assign bus_rd_cyc = bus_sel && !bus_wr;
    assign ien_we     = bus_wr_cyc && bus_addr == ADDR_IEN;
    assign ist_we     = bus_wr_cyc && bus_addr == ADDR_IST;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ctrl_we[g] = bus_wr_cyc && bus_addr == ch_base(g);
        assign ival_we[g] = bus_wr_cyc && bus_addr == ch_base(g) + ADDR_W'(4);

        tmr_channel #(
            .CNT_W     (CNT_W),
            .SYNC_TICKS(SYNC_TICKS)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_en),
            .ctrl_we(ctrl_we[g]),
            .ival_we(ival_we[g]),
            .wdata  (bus_wdata),
            .ctrl_rd(ch_ctrl[g]),
            .ival   (ch_ival[g]),
            .count  (ch_cnt[g]),
            .running(ch_run[g]),
            .expire (ch_expire[g]),
            .oneshot(ch_oneshot[g]),
            .enabled(ch_en[g])
        );
    end

    tmr_irq_ctl #(.NUM_CH(NUM_CH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ien_we(ien_we),
        .ist_we(ist_we),
        .wdata (bus_wdata[NUM_CH-1:0]),
        .expire(ch_expire),
        .ien   (ien),
        .ist   (ist),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd_cyc) begin
            if (bus_addr == ADDR_IEN) bus_rdata = CNT_W'(ien);
            if (bus_addr == ADDR_IST) bus_rdata = CNT_W'(ist);
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ch_base(i))                bus_rdata = CNT_W'(ch_ctrl[i]);
                if (bus_addr == ch_base(i) + ADDR_W'(4))   bus_rdata = ch_ival[i];
                if (bus_addr == ch_base(i) + ADDR_W'(8))   bus_rdata = ch_cnt[i];
            end
        end
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_en,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ien,
    input logic [NUM_CH-1:0]            ist,
    input logic                         ist_we,
    input logic [NUM_CH-1:0]            wbits,
    input logic [NUM_CH-1:0]            ctrl_we,
    input logic [NUM_CH-1:0]            expire,
    input logic [NUM_CH-1:0]            oneshot,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0]            run,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        // R9
        pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ist[i] && !(ist_we && wbits[i]) |=> ist[i]);
        // R9
        pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ist_we && wbits[i] && !expire[i] |=> !ist[i]);
        // R6
        expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> ist[i]);
        // R7
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] && oneshot[i] |=> !ch_en[i] && !run[i]);
        // R8
        frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] && !ctrl_we[i] |=> $stable(cnt[i]));
        // R5
        no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_en && !ctrl_we[i] |=> $stable(cnt[i]));
    end

endmodule

bind mmio_dn_timer tmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .irq    (irq),
    .ien    (ien),
    .ist    (ist),
    .ist_we (ist_we),
    .wbits  (bus_wdata[NUM_CH-1:0]),
    .ctrl_we(ctrl_we),
    .expire (ch_expire),
    .oneshot(ch_oneshot),
    .ch_en  (ch_en),
    .run    (ch_run),
    .cnt    (ch_cnt)
);

// File: tb/mmio_dn_timer_tb.sv
module mmio_dn_timer_tb;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int tick_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    mmio_dn_timer #(.SYNC_TICKS(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    // reference model state
    bit [31:0] m_iv[2], m_cnt[2];
    int        m_pre[2], m_drain[2], m_ps[2], m_src[2];
    bit        m_en[2], m_os[2], m_run[2];
    bit [1:0]  m_ien, m_ist, m_set;
    bit        wc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_iv[c] = 0; m_cnt[c] = 0; m_pre[c] = 0; m_drain[c] = 0;
                m_ps[c] = 0; m_src[c] = 0; m_en[c] = 0; m_os[c] = 0; m_run[c] = 0;
            end
            m_ien = 0; m_ist = 0;
        end else begin
            m_set = 0;
            for (int c = 0; c < 2; c++) begin
                wc = bus_sel && bus_wr && bus_addr == 8'(16 * (c + 1));
                if (wc) begin
                    m_src[c] = int'(bus_wdata[3:2]);
                    m_ps[c]  = int'(bus_wdata[6:4]);
                    m_os[c]  = bus_wdata[7];
                    m_en[c]  = bus_wdata[0];
                    if (bus_wdata[0]) begin
                        m_run[c] = 1; m_drain[c] = 0;
                        if (bus_wdata[1]) begin m_cnt[c] = m_iv[c]; m_pre[c] = 0; end
                    end else if (m_run[c] && m_drain[c] == 0) begin
                        m_drain[c] = SYNC;
                    end
                end else if (tick_en && m_run[c]) begin
                    m_pre[c]++;
                    if (m_pre[c] >= (1 << m_ps[c])) begin
                        m_pre[c] = 0;
                        if (m_cnt[c] == 0) begin
                            m_set[c] = 1;
                            if (m_os[c]) begin m_en[c] = 0; m_run[c] = 0; m_drain[c] = 0; end
                            else m_cnt[c] = m_iv[c];
                        end else m_cnt[c]--;
                    end
                    if (m_drain[c] > 0 && m_run[c]) begin
                        m_drain[c]--;
                        if (m_drain[c] == 0) m_run[c] = 0;
                    end
                end
                if (bus_sel && bus_wr && bus_addr == 8'(16 * (c + 1) + 4)) m_iv[c] = bus_wdata;
            end
            if (bus_sel && bus_wr && bus_addr == 8'h00) m_ien = bus_wdata[1:0];
            if (bus_sel && bus_wr && bus_addr == 8'h04) m_ist = m_ist & ~bus_wdata[1:0];
            m_ist = m_ist | m_set;
        end
    end

    function automatic bit [31:0] model_read(bit [7:0] a);
        for (int c = 0; c < 2; c++) begin
            if (a == 8'(16 * (c + 1)))
                return {24'd0, m_os[c], 3'(m_ps[c]), 2'(m_src[c]), 1'b0, m_en[c]};
            if (a == 8'(16 * (c + 1) + 4)) return m_iv[c];
            if (a == 8'(16 * (c + 1) + 8)) return m_cnt[c];
        end
        if (a == 8'h00) return {30'd0, m_ien};
        if (a == 8'h04) return {30'd0, m_ist};
        return 0;
    endfunction

    // tick source
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (tick_mode)
            1:       tick_en <= 1'b1;
            2:       tick_en <= lfsr[0];
            default: tick_en <= 1'b0;
        endcase
    end

    // R10: interrupt level compared on every clock
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            checks++;
            if (irq !== |(m_ist & m_ien)) begin
                fails++;
                $display("FAIL R10 irq actual=%0b expected=%0b at %0t", irq, |(m_ist & m_ien), $time);
            end
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        bit [31:0] e;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        e = model_read(a);
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, bus_rdata, e);
        end
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        rd(8'h00, tag); rd(8'h04, tag);
        for (int a = 16; a <= 40; a += 4) rd(8'(a), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state
        read_all("R1");
        // R2 map, unmapped, count ignores writes
        wr(8'h00, 32'h3); rd(8'h00, "R2");
        wr(8'h14, 32'd5); rd(8'h14, "R2");
        wr(8'h18, 32'h1234); rd(8'h18, "R2");
        rd(8'h0C, "R2"); rd(8'h3C, "R2");
        // R3 fields, load bit reads 0, source kept
        wr(8'h20, 32'hFE); rd(8'h20, "R3");
        wr(8'h20, 32'h0C); rd(8'h20, "R3"); rd(8'h28, "R3");
        wr(8'h20, 32'h0);
        // R6 periodic under steady ticks
        tick_mode = 1;
        wr(8'h14, 32'd3); wr(8'h10, 32'h03);
        rd(8'h18, "R4");
        for (int i = 0; i < 12; i++) rd(8'h18, "R6");
        rd(8'h04, "R6");
        // R9 clear
        wr(8'h04, 32'h1); rd(8'h04, "R9");
        // R5 prescale under random ticks
        tick_mode = 2;
        wr(8'h14, 32'd4); wr(8'h10, 32'h23);
        for (int i = 0; i < 30; i++) rd(8'h18, "R5");
        // R8 disable coasting
        tick_mode = 1;
        wr(8'h10, 32'h03);
        idle(2);
        wr(8'h10, 32'h00);
        for (int i = 0; i < 5; i++) rd(8'h18, "R8");
        // R5 no ticks, no movement
        tick_mode = 0;
        wr(8'h10, 32'h01); idle(5); rd(8'h18, "R5");
        // R4 resume without load
        tick_mode = 1;
        idle(2); rd(8'h18, "R4");
        wr(8'h10, 32'h00); idle(4); rd(8'h18, "R4");
        // R7 one-shot on channel 1
        wr(8'h24, 32'd4); wr(8'h20, 32'h83);
        for (int i = 0; i < 8; i++) rd(8'h28, "R7");
        rd(8'h20, "R7"); rd(8'h04, "R7");
        idle(4); rd(8'h28, "R7");
        // R10 masking
        wr(8'h00, 32'h0); idle(3); rd(8'h04, "R10");
        wr(8'h00, 32'h2); idle(2);
        wr(8'h04, 32'h2); rd(8'h04, "R9");
        // R9 set beats clear: interval 0 expires on every tick
        wr(8'h14, 32'd0); wr(8'h10, 32'h03); idle(2);
        wr(8'h04, 32'h1); rd(8'h04, "R9");
        wr(8'h00, 32'h1); idle(3);
        wr(8'h10, 32'h00); idle(6);
        read_all("R2");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule